// File: doc/BRIEF.md
# Dual-Mode PWM Generator with Deferred Updates

A single pulse-width generator: one counter drives two outputs, A and B. In count-down mode the counter falls from the period value to zero and reloads, so both outputs rise together (left-aligned pulses). In up/down mode it climbs from zero to the period value and falls back, so the two pulses share a common centre.

Period and the two compare values are written through a small write port into shadow registers. A shadow value reaches the working register only when the counter sits at zero. In synchronous mode it also waits for an external sync pulse, so several generators sharing that pulse switch together. A debug-halt input either freezes the counter at its next zero or is ignored, as selected. Two one-cycle status pulses mark the zero and period-value points of each cycle.

Top module: `pwm_gen_top`

## Requirements
- R1: Count-down mode (`cnt_updown`=0): the counter runs period value L, L-1 ... 0 and reloads L, so `zero_pulse` and `load_pulse` each fire once every L+1 clocks.
- R2: Up/down mode (`cnt_updown`=1): the counter runs 0 up to L and back down to 0, so `zero_pulse` fires once every 2L clocks.
- R3: Count-down mode: an output goes high in the cycle after the counter equals L and goes low in the cycle after it equals that output's compare value C while falling. It is high for L-C clocks per period.
- R4: Up/down mode: an output goes high after a compare match while rising and low after a compare match while falling. It is high for 2(L-C) clocks per period.
- R5: Writes go to shadow registers (`wr_sel` 0 = period, 1 = compare A, 2 = compare B, 3 = nothing). Pending values become active only in a running cycle in which the counter is zero.
- R6: With `sync_mode`=1, pending values also wait for a `sync_pulse`. A pulse is remembered until the next running zero cycle, which consumes it.
- R7: A second write to the same shadow register before it is applied replaces the first. Only the latest value takes effect.
- R8: With `dbg_halt`=1 and `dbg_freeze`=1, the counter runs on to zero and holds there, with no status pulses and stable outputs, until the halt drops. With `dbg_freeze`=0 the halt has no effect.
- R9: With `en`=0 the counter holds its value, both outputs are low from the next cycle, and no status pulses are produced.
- R10: After reset the counter, all registers and all outputs are zero.
- R11: In count-down mode a compare value equal to L gives a constantly low output (zero width): the clear action wins over the set action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| cnt_updown | input | 1 | 0 = count-down, 1 = up/down |
| sync_mode | input | 1 | 1 = updates also wait for sync_pulse |
| sync_pulse | input | 1 | External update strobe |
| dbg_halt | input | 1 | Debug halt request |
| dbg_freeze | input | 1 | 1 = halt freezes at zero, 0 = halt ignored |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 2 | Register select (0 period, 1 cmp A, 2 cmp B) |
| wr_data | input | CNT_W | Write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| zero_pulse | output | 1 | One-cycle pulse after a zero count |
| load_pulse | output | 1 | One-cycle pulse after the count equals the period value |

## Verification
The bench builds the generator with an 8-bit counter. Periods of a few tens of clocks then let every window cover several whole cycles in both modes. With the narrow counter the count-down reload, the up/down turn points and the equal-to-period compare are all reached many times within a short run. A behavioural reference model runs beside the design and is compared on every clock. Windowed counts of output high time and status pulses confirm widths and periods, deferred and synchronised updates, pending overwrite, debug freeze and disable.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {ACT_KEEP = 2'd0, ACT_LOW = 2'd1, ACT_HIGH = 2'd2} act_e;

  typedef struct packed {
    act_e on_zero;
    act_e on_load;
    act_e on_cmp_up;
    act_e on_cmp_dn;
  } act_set_t;

  localparam int NUM_REGS = 3;
  localparam logic [1:0] SEL_PERIOD = 2'd0;
  localparam logic [1:0] SEL_CMP_A  = 2'd1;
  localparam logic [1:0] SEL_CMP_B  = 2'd2;

  function automatic act_set_t mode_actions(input logic updown);
    act_set_t s;
    s.on_zero = ACT_KEEP;
    if (updown) begin
      s.on_load   = ACT_KEEP;
      s.on_cmp_up = ACT_HIGH;
    end else begin
      s.on_load   = ACT_HIGH;
      s.on_cmp_up = ACT_KEEP;
    end
    s.on_cmp_dn = ACT_LOW;
    return s;
  endfunction

  function automatic logic do_act(input logic cur, input act_e a, input logic hit);
    if (!hit) return cur;
    case (a)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [1:0]                     wr_sel,
  input  logic [CNT_W-1:0]               wr_data,
  input  logic                           apply,
  output logic [NUM_REGS-1:0][CNT_W-1:0] act_q,
  output logic [NUM_REGS-1:0][CNT_W-1:0] nxt
);
  logic [NUM_REGS-1:0][CNT_W-1:0] shd_q;
  logic [NUM_REGS-1:0]            pend_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic hit;
    assign hit    = wr_en && (wr_sel == 2'(i));
    assign nxt[i] = (apply && pend_q[i]) ? shd_q[i] : act_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        shd_q[i]  <= '0;
        pend_q[i] <= 1'b0;
        act_q[i]  <= '0;
      end else begin
        if (apply && pend_q[i]) act_q[i] <= shd_q[i];
        if (hit) begin
          shd_q[i]  <= wr_data;
          pend_q[i] <= 1'b1;
        end else if (apply) begin
          pend_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             updown,
  input  logic [CNT_W-1:0] ld_cur,
  input  logic [CNT_W-1:0] ld_next,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_up_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b0;
    end else if (run) begin
      if (!updown) begin
        cnt_q <= (cnt_q == '0) ? ld_next : cnt_q - ONE;
      end else if (dir_up_q) begin
        if (cnt_q >= ld_cur) begin
          dir_up_q <= 1'b0;
          cnt_q    <= cnt_q - ONE;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else if (cnt_q == '0) begin
        if (ld_next != '0) begin
          dir_up_q <= 1'b1;
          cnt_q    <= ONE;
        end
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/pwm_out_ctl.sv
module pwm_out_ctl
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             updown,
  input  logic             dir_up,
  input  logic             ev_zero,
  input  logic             ev_load,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             pwm_q
);
  act_set_t acts;
  logic     rising, hit_up, hit_dn, nxt;

  assign acts   = mode_actions(updown);
  assign rising = updown && dir_up;
  assign hit_up = rising && (cnt == cmp);
  assign hit_dn = !rising && (cnt == cmp);

  // later actions win: zero, load, compare up, compare down
  always_comb begin
    nxt = pwm_q;
    nxt = do_act(nxt, acts.on_zero,   ev_zero);
    nxt = do_act(nxt, acts.on_load,   ev_load);
    nxt = do_act(nxt, acts.on_cmp_up, hit_up);
    nxt = do_act(nxt, acts.on_cmp_dn, hit_dn);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) pwm_q <= 1'b0;
    else if (run)   pwm_q <= nxt;
  end
endmodule

// File: rtl/pwm_gen_top.sv
module pwm_gen_top
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cnt_updown,
  input  logic             sync_mode,
  input  logic             sync_pulse,
  input  logic             dbg_halt,
  input  logic             dbg_freeze,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             zero_pulse,
  output logic             load_pulse
);
  logic [NUM_REGS-1:0][CNT_W-1:0] act_q, nxt;
  logic [CNT_W-1:0] cnt_q, ld_act;
  logic dir_up_q, at_zero, run, apply, sync_seen_q;
  logic [1:0] pwm_vec;

  assign ld_act  = act_q[SEL_PERIOD];
  assign at_zero = (cnt_q == '0);
  assign run     = en && !(dbg_halt && dbg_freeze && at_zero);
  assign apply   = run && at_zero && (!sync_mode || sync_seen_q || sync_pulse);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_seen_q <= 1'b0;
      zero_pulse  <= 1'b0;
      load_pulse  <= 1'b0;
    end else begin
      sync_seen_q <= (run && at_zero) ? 1'b0 : (sync_seen_q || sync_pulse);
      zero_pulse  <= run && at_zero;
      load_pulse  <= run && (cnt_q == ld_act);
    end
  end

  pwm_regbank #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .apply(apply), .act_q(act_q), .nxt(nxt)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .updown(cnt_updown),
    .ld_cur(ld_act), .ld_next(nxt[SEL_PERIOD]),
    .cnt_q(cnt_q), .dir_up_q(dir_up_q)
  );

  for (genvar k = 0; k < 2; k++) begin : g_out
    pwm_out_ctl #(.CNT_W(CNT_W)) u_out (
      .clk(clk), .rst(rst), .en(en), .run(run), .updown(cnt_updown),
      .dir_up(dir_up_q), .ev_zero(at_zero), .ev_load(cnt_q == ld_act),
      .cnt(cnt_q), .cmp(act_q[SEL_CMP_A + k]), .pwm_q(pwm_vec[k])
    );
  end

  assign pwm_a = pwm_vec[0];
  assign pwm_b = pwm_vec[1];
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             dbg_halt,
  input logic             dbg_freeze,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             zero_pulse,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] ld_act
);
  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!pwm_a && !pwm_b && !zero_pulse && cnt_q == '0));

  // R9
  dis_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm_a && !pwm_b && !zero_pulse));

  // R9
  dis_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (en && dbg_halt && dbg_freeze && cnt_q == '0) |=> (cnt_q == '0 && $stable(pwm_a) && $stable(pwm_b)));

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> $stable(ld_act));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= ld_act);
endmodule

bind pwm_gen_top pwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .dbg_halt(dbg_halt), .dbg_freeze(dbg_freeze),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .zero_pulse(zero_pulse),
  .cnt_q(cnt_q), .ld_act(ld_act)
);

// File: tb/sim_pwm_gen_top.sv
`timescale 1ns/1ps
module sim_pwm_gen_top;
  localparam int W = 8;

  logic clk = 0, rst = 1, en = 0, cnt_updown = 0, sync_mode = 0, sync_pulse = 0;
  logic dbg_halt = 0, dbg_freeze = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [W-1:0] wr_data = 0;
  logic pwm_a, pwm_b, zero_pulse, load_pulse;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_gen_top #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .cnt_updown(cnt_updown), .sync_mode(sync_mode),
    .sync_pulse(sync_pulse), .dbg_halt(dbg_halt), .dbg_freeze(dbg_freeze),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .zero_pulse(zero_pulse), .load_pulse(load_pulse)
  );

  // behavioural reference model
  int m_cnt, m_up, m_seen;
  int m_act[3], m_shd[3], m_pnd[3];
  bit m_a, m_b, m_z, m_l;

  function automatic bit step_out(bit cur, int cmp, bit ld_hit);
    bit rising = cnt_updown && (m_up != 0);
    bit v = cur;
    if (!cnt_updown && ld_hit) v = 1;
    if (rising && m_cnt == cmp) v = 1;
    if (!rising && m_cnt == cmp) v = 0;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_up = 0; m_seen = 0;
      for (int i = 0; i < 3; i++) begin m_act[i] = 0; m_shd[i] = 0; m_pnd[i] = 0; end
      m_a = 0; m_b = 0; m_z = 0; m_l = 0;
    end else begin
      bit run, zero, ldh, app;
      int nl;
      zero = (m_cnt == 0);
      ldh  = (m_cnt == m_act[0]);
      run  = en && !(dbg_halt && dbg_freeze && zero);
      app  = run && zero && (!sync_mode || m_seen != 0 || sync_pulse);
      if (!en) begin
        m_a = 0; m_b = 0;
      end else if (run) begin
        m_a = step_out(m_a, m_act[1], ldh);
        m_b = step_out(m_b, m_act[2], ldh);
      end
      m_z = run && zero;
      m_l = run && ldh;
      nl = (app && m_pnd[0] != 0) ? m_shd[0] : m_act[0];
      if (run) begin
        if (!cnt_updown) m_cnt = zero ? nl : m_cnt - 1;
        else if (m_up != 0) begin
          if (m_cnt >= m_act[0]) begin m_up = 0; m_cnt = m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else if (zero) begin
          if (nl != 0) begin m_up = 1; m_cnt = 1; end
        end else m_cnt = m_cnt - 1;
      end
      m_seen = (run && zero) ? 0 : ((m_seen != 0 || sync_pulse) ? 1 : 0);
      for (int i = 0; i < 3; i++) begin
        if (app && m_pnd[i] != 0) m_act[i] = m_shd[i];
        if (wr_en && wr_sel == 2'(i)) begin m_shd[i] = int'(wr_data); m_pnd[i] = 1; end
        else if (app) m_pnd[i] = 0;
      end
    end
  end

  // per-clock comparison (R1 R2 R3 R4 R5 R6 R7 R8 R9 checked against the model)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pwm_a !== m_a || pwm_b !== m_b || zero_pulse !== m_z || load_pulse !== m_l) begin
        errors++;
        $display("FAIL model R3/R4 t=%0t actual a%0b b%0b z%0b l%0b expected a%0b b%0b z%0b l%0b",
                 $time, pwm_a, pwm_b, zero_pulse, load_pulse, m_a, m_b, m_z, m_l);
      end
    end
  end

  task automatic wr(input logic [1:0] s, input int d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = W'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic window(input int n, output int ha, output int hb, output int nz, output int nl);
    ha = 0; hb = 0; nz = 0; nl = 0;
    repeat (n) begin
      @(negedge clk);
      ha += pwm_a; hb += pwm_b; nz += zero_pulse; nl += load_pulse;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; en = 0; sync_mode = 0; dbg_halt = 0; dbg_freeze = 0;
    idle(2); rst = 0;
  endtask

  initial begin
    int ha, hb, nz, nl;
    idle(3);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 pwm_a", pwm_a, 0);
    chk("R10 pwm_b", pwm_b, 0);
    chk("R10 zero_pulse", zero_pulse, 0);

    // down mode: L=9, A W=4, B compare = L (R11)
    wr(0, 9); wr(1, 5); wr(2, 9);
    @(negedge clk); en = 1;
    idle(30);
    window(30, ha, hb, nz, nl);
    chk("R1 zero count", nz, 3);
    chk("R1 load count", nl, 3);
    chk("R3 pwm_a width", ha, 12);
    chk("R11 pwm_b zero width", hb, 0);

    // R5 / R7: two writes before the next zero, last one wins
    wr(1, 3); wr(1, 7);
    idle(25);
    window(30, ha, hb, nz, nl);
    chk("R7 pwm_a width after overwrite", ha, 6);

    // R6: sync mode holds a new period until sync_pulse
    @(negedge clk); sync_mode = 1;
    wr(0, 5);
    idle(20);
    window(30, ha, hb, nz, nl);
    chk("R6 period held without sync", nz, 3);
    @(negedge clk); sync_pulse = 1;
    @(negedge clk); sync_pulse = 0;
    idle(20);
    window(30, ha, hb, nz, nl);
    chk("R6 period after sync", nz, 5);
    @(negedge clk); sync_mode = 0;
    wr(0, 9);
    idle(25);

    // R8: freeze at zero, then release, then run mode ignores halt
    @(negedge clk); dbg_freeze = 1; dbg_halt = 1;
    idle(15);
    window(30, ha, hb, nz, nl);
    chk("R8 frozen zero pulses", nz, 0);
    chk("R8 frozen load pulses", nl, 0);
    @(negedge clk); dbg_halt = 0;
    idle(5);
    window(30, ha, hb, nz, nl);
    chk("R8 released zero pulses", nz, 3);
    @(negedge clk); dbg_freeze = 0; dbg_halt = 1;
    window(30, ha, hb, nz, nl);
    chk("R8 run-mode halt ignored", nz, 3);
    @(negedge clk); dbg_halt = 0;

    // R9: disable
    @(negedge clk); en = 0;
    window(20, ha, hb, nz, nl);
    chk("R9 outputs low a", ha, 0);
    chk("R9 outputs low b", hb, 0);
    chk("R9 no pulses", nz + nl, 0);

    // up/down mode: L=8, A compare 5 (W=6), B compare 7 (W=2)
    do_reset();
    @(negedge clk); cnt_updown = 1;
    wr(0, 8); wr(1, 5); wr(2, 7);
    @(negedge clk); en = 1;
    idle(40);
    window(48, ha, hb, nz, nl);
    chk("R2 zero count", nz, 3);
    chk("R4 pwm_a width", ha, 18);
    chk("R4 pwm_b width", hb, 6);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule